// File: doc/BRIEF.md
# Register-Stack Base Pointer Interlock

This block guards the decode stage of a pipeline whose local registers have no fixed numbers. Each local operand carries only an offset, and the physical register is found by adding that offset to a slot index taken from a base pointer held in a global register. When an instruction changes the base pointer, the new value is produced in execute. The instruction directly behind it in decode would otherwise build its local register numbers from the stale pointer. The block detects that case and holds decode for one cycle, so no software padding is ever needed.

Each cycle the block takes three decoded operand descriptors (source A, source B, destination), each marked local or global. It also takes a flag for an instruction that reads the pointer register as data, a flag for an instruction that writes it, and the pointer value coming out of execute. It returns a stall, an issue strobe and one absolute register number per operand. The pointer is treated as a byte address: its slot index is bits [8:2], which gives a 128-entry local file. Absolute numbers 0 to 127 are globals and 128 to 255 are locals.

A two-state controller tracks the pointer. In `PTR_SETTLED` no pointer write is in flight. Issuing a pointer-writing instruction takes the controller to `PTR_IN_FLIGHT`. In that state the execute result is captured as the new pointer at the end of the cycle. The controller then returns to `PTR_SETTLED`, or stays in `PTR_IN_FLIGHT` if the instruction issuing in that same cycle also writes the pointer.

Top module: `rsp_interlock`

## Requirements
- R1: Out of reset the pointer slot is 0, no stall is raised, and a local operand with offset k maps to absolute number 128 + k.
- R2: A local operand maps to absolute number 128 + ((slot + offset) mod 128), where slot is bits [8:2] of the current pointer.
- R3: A global operand maps to its own index, 0 to 127, with bit 7 of the absolute number clear.
- R4: In the cycle right after a pointer-writing instruction issues, a valid decode instruction with any local operand (source A, source B or destination) raises stall.
- R5: In that same cycle, a valid decode instruction that reads the pointer register as data raises stall even with no local operand.
- R6: In that cycle, a valid instruction with no local operand that does not read the pointer issues at once, with no stall.
- R7: Stall lasts exactly one cycle. In the next cycle the same instruction issues, and its local numbers are formed from the updated pointer.
- R8: The execute pointer value is captured only in the cycle after a pointer-writing issue. At any other time its value has no effect on the register numbers. Pointer bits other than [8:2] never affect them.
- R9: Issue is high exactly when decode is valid and not stalled. Stall is never raised without a valid decode instruction. An empty decode slot after a pointer write still lets the write complete.
- R10: The sum of slot and offset wraps modulo 128.
- R11: Back-to-back pointer writes with no local operands both issue, and the second value is the one used afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_opnd_local | input | 3 | Per operand: 1 = local (offset), 0 = global; bit 0 source A, bit 1 source B, bit 2 destination |
| dec_opnd_idx | input | 21 | Per operand 7-bit offset or global index, operand i at bits [7i+6:7i] |
| dec_reads_sp | input | 1 | Instruction reads the pointer register as a data operand |
| dec_writes_sp | input | 1 | Instruction writes the pointer register |
| ex_sp_data | input | 32 | New pointer value from execute |
| stall | output | 1 | Hold decode and send a bubble to execute |
| issue | output | 1 | Decode instruction advances this cycle |
| eff_reg | output | 24 | Per operand 8-bit absolute register number, operand i at bits [8i+7:8i] |

## Verification
Stall, issue and the absolute register numbers are combinational from the decode inputs and the registered pointer state, so each is due in the same cycle as the instruction presented. A pointer value on `ex_sp_data` takes effect one edge later, in the cycle after the one in which it was presented. The bench drives inputs at the falling edge and samples 2 ns later, well before the next rising edge. It expects the stall in the first cycle after the writer issues and the new numbers in the second. Values of `ex_sp_data` offered outside the capture cycle are checked to leave the numbers unchanged.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    // Tracking state of the register-stack base pointer
    typedef enum logic [0:0] {
        PTR_SETTLED   = 1'b0,   // pointer value in the block is current
        PTR_IN_FLIGHT = 1'b1    // writer sits in execute, value arrives this cycle
    } ptr_state_e;

    localparam int unsigned LOCAL_REGS_DEF = 128;
    localparam int unsigned NUM_OPND_DEF   = 3;

endpackage

// File: rtl/rsp_ptr_fsm.sv
module rsp_ptr_fsm
    import rsp_pkg::*;
#(
    parameter int unsigned PTR_W      = 32,
    parameter int unsigned IDX_W      = 7,
    parameter int unsigned SLOT_LSB   = 2,
    parameter logic [IDX_W-1:0] RESET_SLOT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_wr,
    input  logic [PTR_W-1:0] ex_sp_data,
    output logic             pending,
    output logic [IDX_W-1:0] base_slot
);

    ptr_state_e       state_q, state_d;
    logic             capture;
    logic [IDX_W-1:0] slot_q;
    logic             ptr_unused;

    // only the slot field reaches register addressing
    assign ptr_unused = ^ex_sp_data;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PTR_SETTLED;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTR_SETTLED:   state_d = issue_wr ? PTR_IN_FLIGHT : PTR_SETTLED;
            PTR_IN_FLIGHT: state_d = issue_wr ? PTR_IN_FLIGHT : PTR_SETTLED;
            default:       state_d = PTR_SETTLED;
        endcase
    end

    // outputs
    always_comb begin
        pending = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            PTR_SETTLED:   begin pending = 1'b0; capture = 1'b0; end
            PTR_IN_FLIGHT: begin pending = 1'b1; capture = 1'b1; end
            default:       begin pending = 1'b0; capture = 1'b0; end
        endcase
    end

    // base slot register
    always_ff @(posedge clk) begin
        if (!rst_n)       slot_q <= RESET_SLOT;
        else if (capture) slot_q <= ex_sp_data[SLOT_LSB +: IDX_W];
    end

    assign base_slot = slot_q;

endmodule

// File: rtl/rsp_hazard.sv
module rsp_hazard #(
    parameter int unsigned NUM_OPND = 3
) (
    input  logic                dec_valid,
    input  logic [NUM_OPND-1:0] opnd_local,
    input  logic                reads_sp,
    input  logic                writes_sp,
    input  logic                pending,
    output logic                stall,
    output logic                issue,
    output logic                issue_wr
);

    logic needs_ptr;

    // an instruction depends on the pointer if it forms any local
    // address or reads the pointer register itself
    assign needs_ptr = (|opnd_local) | reads_sp;
    assign stall     = dec_valid & pending & needs_ptr;
    assign issue     = dec_valid & ~stall;
    assign issue_wr  = issue & writes_sp;

endmodule

// File: rtl/rsp_addr_gen.sv
module rsp_addr_gen #(
    parameter int unsigned IDX_W = 7
) (
    input  logic             is_local,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] base_slot,
    output logic [IDX_W:0]   eff
);

    logic [IDX_W-1:0] wrapped;

    // carry out of the slot field is dropped: modulo the local file size
    assign wrapped = base_slot + idx;
    assign eff     = is_local ? {1'b1, wrapped} : {1'b0, idx};

endmodule

// File: rtl/rsp_interlock.sv
module rsp_interlock
    import rsp_pkg::*;
#(
    parameter int unsigned LOCAL_REGS = LOCAL_REGS_DEF,
    parameter int unsigned NUM_OPND   = NUM_OPND_DEF,
    parameter int unsigned PTR_W      = 32,
    parameter int unsigned SLOT_LSB   = 2,
    localparam int unsigned IDX_W     = $clog2(LOCAL_REGS),
    localparam int unsigned EFF_W     = IDX_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dec_valid,
    input  logic [NUM_OPND-1:0]       dec_opnd_local,
    input  logic [NUM_OPND*IDX_W-1:0] dec_opnd_idx,
    input  logic                      dec_reads_sp,
    input  logic                      dec_writes_sp,
    input  logic [PTR_W-1:0]          ex_sp_data,
    output logic                      stall,
    output logic                      issue,
    output logic [NUM_OPND*EFF_W-1:0] eff_reg
);

    logic             pending;
    logic             issue_wr;
    logic [IDX_W-1:0] base_slot;

    rsp_hazard #(.NUM_OPND(NUM_OPND)) hazard_i (
        .dec_valid  (dec_valid),
        .opnd_local (dec_opnd_local),
        .reads_sp   (dec_reads_sp),
        .writes_sp  (dec_writes_sp),
        .pending    (pending),
        .stall      (stall),
        .issue      (issue),
        .issue_wr   (issue_wr)
    );

    rsp_ptr_fsm #(
        .PTR_W    (PTR_W),
        .IDX_W    (IDX_W),
        .SLOT_LSB (SLOT_LSB)
    ) ptr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_wr   (issue_wr),
        .ex_sp_data (ex_sp_data),
        .pending    (pending),
        .base_slot  (base_slot)
    );

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        rsp_addr_gen #(.IDX_W(IDX_W)) agen_i (
            .is_local  (dec_opnd_local[g]),
            .idx       (dec_opnd_idx[g*IDX_W +: IDX_W]),
            .base_slot (base_slot),
            .eff       (eff_reg[g*EFF_W +: EFF_W])
        );
    end

endmodule

// File: rtl/rsp_interlock_chk.sv
module rsp_interlock_chk #(
    parameter int unsigned NUM_OPND = 3,
    parameter int unsigned IDX_W    = 7,
    parameter int unsigned PTR_W    = 32,
    parameter int unsigned SLOT_LSB = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        dec_valid,
    input logic [NUM_OPND-1:0]         dec_opnd_local,
    input logic [NUM_OPND*IDX_W-1:0]   dec_opnd_idx,
    input logic                        dec_reads_sp,
    input logic                        dec_writes_sp,
    input logic [PTR_W-1:0]            ex_sp_data,
    input logic                        stall,
    input logic                        issue,
    input logic [NUM_OPND*(IDX_W+1)-1:0] eff_reg,
    input logic [IDX_W-1:0]            base_slot
);

    assert_stall_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    assert_local_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_writes_sp) ##1 (dec_valid && (|dec_opnd_local)) |-> stall);

    assert_ptr_read_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_writes_sp) ##1 (dec_valid && dec_reads_sp) |-> stall);

    assert_no_spurious_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && dec_writes_sp) |=> !stall);

    assert_ptr_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_writes_sp) ##1 1'b1 |=>
            base_slot == $past(ex_sp_data[SLOT_LSB +: IDX_W]));

    assert_stall_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (dec_valid && !issue));

    assert_global_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_opnd_local[0] |-> eff_reg[IDX_W:0] == {1'b0, dec_opnd_idx[IDX_W-1:0]});

endmodule

bind rsp_interlock rsp_interlock_chk #(
    .NUM_OPND (NUM_OPND),
    .IDX_W    (IDX_W),
    .PTR_W    (PTR_W),
    .SLOT_LSB (SLOT_LSB)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .dec_valid      (dec_valid),
    .dec_opnd_local (dec_opnd_local),
    .dec_opnd_idx   (dec_opnd_idx),
    .dec_reads_sp   (dec_reads_sp),
    .dec_writes_sp  (dec_writes_sp),
    .ex_sp_data     (ex_sp_data),
    .stall          (stall),
    .issue          (issue),
    .eff_reg        (eff_reg),
    .base_slot      (base_slot)
);

// File: tb/rsp_interlock_tb.sv
module rsp_interlock_tb_top;

    localparam time HALF = 4ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dec_valid;
    logic [2:0]  dec_opnd_local;
    logic [20:0] dec_opnd_idx;
    logic        dec_reads_sp;
    logic        dec_writes_sp;
    logic [31:0] ex_sp_data;
    logic        stall;
    logic        issue;
    logic [23:0] eff_reg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #HALF clk = ~clk;

    rsp_interlock dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .dec_valid      (dec_valid),
        .dec_opnd_local (dec_opnd_local),
        .dec_opnd_idx   (dec_opnd_idx),
        .dec_reads_sp   (dec_reads_sp),
        .dec_writes_sp  (dec_writes_sp),
        .ex_sp_data     (ex_sp_data),
        .stall          (stall),
        .issue          (issue),
        .eff_reg        (eff_reg)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one decode cycle: drive at the falling edge, settle, return for sampling
    task automatic cyc(input logic v, input logic [2:0] loc,
                       input logic [6:0] i0, input logic [6:0] i1, input logic [6:0] i2,
                       input logic rd, input logic wr, input logic [31:0] ex);
        @(negedge clk);
        dec_valid      = v;
        dec_opnd_local = loc;
        dec_opnd_idx   = {i2, i1, i0};
        dec_reads_sp   = rd;
        dec_writes_sp  = wr;
        ex_sp_data     = ex;
        #2ns;
    endtask

    task automatic idle();
        cyc(1'b0, 3'b000, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 32'h0);
    endtask

    // pointer write with no local operand; issues freely
    task automatic write_ptr(input string req);
        cyc(1'b1, 3'b000, 7'd1, 7'd2, 7'd3, 1'b0, 1'b1, 32'hDEAD_BEEF);
        chk(req, "writer issue", issue, 1);
        chk(req, "writer stall", stall, 0);
    endtask

    task automatic t_reset();
        idle();
        chk("R1", "stall at reset", stall, 0);
        chk("R9", "issue when idle", issue, 0);
        cyc(1'b1, 3'b111, 7'd5, 7'd0, 7'd127, 1'b0, 1'b0, 32'h0);
        chk("R1", "stall first insn", stall, 0);
        chk("R1", "eff A at reset", eff_reg[7:0], 8'h85);
        chk("R2", "eff D at reset", eff_reg[23:16], 8'hFF);
        idle();
    endtask

    task automatic t_global();
        cyc(1'b1, 3'b000, 7'd3, 7'd64, 7'd1, 1'b0, 1'b0, 32'h0);
        chk("R3", "global A", eff_reg[7:0], 8'h03);
        chk("R3", "global B", eff_reg[15:8], 8'h40);
        chk("R3", "global D", eff_reg[23:16], 8'h01);
        idle();
    endtask

    task automatic t_local_hazard();
        write_ptr("R4");
        cyc(1'b1, 3'b001, 7'd2, 7'd0, 7'd0, 1'b0, 1'b0, 32'h0000_0040);
        chk("R4", "stall on local A", stall, 1);
        chk("R9", "no issue while stalled", issue, 0);
        cyc(1'b1, 3'b001, 7'd2, 7'd0, 7'd0, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk("R7", "stall released", stall, 0);
        chk("R7", "issue after stall", issue, 1);
        chk("R7", "new pointer used", eff_reg[7:0], 8'h92);
        cyc(1'b1, 3'b001, 7'd2, 7'd0, 7'd0, 1'b0, 1'b0, 32'h1234_5678);
        chk("R8", "late ex value ignored", eff_reg[7:0], 8'h92);
        idle();
    endtask

    task automatic t_sp_read();
        write_ptr("R5");
        cyc(1'b1, 3'b000, 7'd9, 7'd9, 7'd9, 1'b1, 1'b0, 32'h0000_0100);
        chk("R5", "stall on pointer read", stall, 1);
        cyc(1'b1, 3'b000, 7'd9, 7'd9, 7'd9, 1'b1, 1'b0, 32'h0);
        chk("R7", "pointer read issues", issue, 1);
        cyc(1'b1, 3'b001, 7'd1, 7'd0, 7'd0, 1'b0, 1'b0, 32'h0);
        chk("R2", "slot 64 plus 1", eff_reg[7:0], 8'hC1);
        idle();
    endtask

    task automatic t_dest_local();
        write_ptr("R4");
        cyc(1'b1, 3'b100, 7'd0, 7'd0, 7'd7, 1'b0, 1'b0, 32'h0000_000C);
        chk("R4", "stall on local dest", stall, 1);
        cyc(1'b1, 3'b100, 7'd0, 7'd0, 7'd7, 1'b0, 1'b0, 32'h0);
        chk("R7", "dest uses new slot", eff_reg[23:16], 8'h8A);
        chk("R3", "global A beside local dest", eff_reg[7:0], 8'h00);
        idle();
    endtask

    task automatic t_no_dep();
        write_ptr("R6");
        cyc(1'b1, 3'b000, 7'd4, 7'd5, 7'd6, 1'b0, 1'b0, 32'h0000_0080);
        chk("R6", "independent insn no stall", stall, 0);
        chk("R6", "independent insn issues", issue, 1);
        cyc(1'b1, 3'b010, 7'd0, 7'd1, 7'd0, 1'b0, 1'b0, 32'h0);
        chk("R6", "pointer landed", eff_reg[15:8], 8'hA1);
        idle();
    endtask

    task automatic t_empty_slot();
        write_ptr("R9");
        cyc(1'b0, 3'b001, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 32'h0000_0020);
        chk("R9", "no stall when empty", stall, 0);
        chk("R9", "no issue when empty", issue, 0);
        cyc(1'b1, 3'b001, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 32'h0);
        chk("R9", "write completed", eff_reg[7:0], 8'h88);
        chk("R9", "no late stall", stall, 0);
        idle();
    endtask

    task automatic t_wrap();
        write_ptr("R10");
        idle();
        // bits [8:2] = 124, upper bits set
        cyc(1'b0, 3'b000, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 32'h0);
        write_ptr("R10");
        cyc(1'b0, 3'b000, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 32'hFFFF_F1F0);
        cyc(1'b1, 3'b001, 7'd10, 7'd0, 7'd0, 1'b0, 1'b0, 32'h0);
        chk("R10", "124 + 10 wraps to 6", eff_reg[7:0], 8'h86);
        chk("R8", "upper pointer bits ignored", eff_reg[7:0], 8'h86);
        idle();
    endtask

    task automatic t_back_to_back();
        write_ptr("R11");
        cyc(1'b1, 3'b000, 7'd0, 7'd0, 7'd0, 1'b0, 1'b1, 32'h0000_0040);
        chk("R11", "second writer no stall", stall, 0);
        chk("R11", "second writer issues", issue, 1);
        cyc(1'b0, 3'b000, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 32'h0000_0080);
        cyc(1'b1, 3'b001, 7'd0, 7'd0, 7'd0, 1'b0, 1'b0, 32'h0);
        chk("R11", "second value wins", eff_reg[7:0], 8'hA0);
        idle();
    endtask

    initial begin
        rst_n          = 1'b0;
        dec_valid      = 1'b0;
        dec_opnd_local = '0;
        dec_opnd_idx   = '0;
        dec_reads_sp   = 1'b0;
        dec_writes_sp  = 1'b0;
        ex_sp_data     = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_global();
        t_local_hazard();
        t_sp_read();
        t_dest_local();
        t_no_dep();
        t_empty_slot();
        t_wrap();
        t_back_to_back();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(HALF * 2 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1-watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule